// File: doc/BRIEF.md
# Pulse-Length-Coded Downlink Decoder

This block sits on the receive side of a low-frequency tag. It takes the demodulated field level, already synchronised to the local clock, and turns the frames sent by a reader into raw bits. Each symbol has two parts. The first is a short field-off gap. The second is a field-on interval, and the length of that interval carries the symbol. The decoder measures both parts in time units, where one unit is `CLKS_PER_UNIT` clock cycles. It then sorts the on interval into a zero, a one or an end-of-frame mark, using inclusive tolerance windows.

Decoded bits come out one at a time as a strobe plus a bit value. A frame closes with an end-of-frame strobe, and the number of bits in the frame is presented together with that strobe. A malformed symbol raises a protocol error and discards the rest of the frame. If the field stays off for a long time, the decoder gives a single-cycle receiver-reset pulse and returns to idle. Command interpretation is left to the logic that consumes the bits.

Top module: `pulse_len_decoder`

## Requirements
- R1: After a valid gap, an on interval of `ZERO_MIN`..`ZERO_MAX` units (default 14..22, inclusive) gives one `bitValid` pulse with `bitValue` = 0.
- R2: After a valid gap, an on interval of `ONE_MIN`..`ONE_MAX` units (default 26..32, inclusive) gives one `bitValid` pulse with `bitValue` = 1.
- R3: When an on interval inside a frame reaches `EOF_MIN` units (default 38), `frameEnd` pulses while the field is still on. At the same time, `frameBits` holds the number of bits decoded since the frame's first falling edge.
- R4: An on interval inside a frame that falls in none of the windows raises `protoErr` and produces no bit. With the defaults these lengths are below 14, 23..25 and 33..37.
- R5: An off gap of `GAP_MIN`..`GAP_MAX` units (default 4..10) is accepted. A gap of any other length that ends in a rising edge raises `protoErr`.
- R6: After a protocol error, no bit and no `frameEnd` are produced until the field has stayed on for `EOF_MIN` units. After that the decoder is idle, and the next falling edge starts a new frame.
- R7: A field-off period of `RESET_UNITS` units (default 4375, which is 35 ms at 8 µs per unit) gives exactly one single-cycle `rxReset` pulse, however long the field then stays off, and returns the decoder to idle without an error.
- R8: Intervals are measured from each field edge in whole units. A level held for N·`CLKS_PER_UNIT` cycles counts as N units, and one cycle less counts as N−1.
- R9: While `rstN` is low and after its release, all output strobes are low until the field produces a qualifying event.
- R10: `bitValid`, `frameEnd`, `protoErr` and `rxReset` are single-cycle pulses, and at most one of them is high in any cycle.
- R11: Each new frame starts counting bits from zero. A frame made only of a gap and an end-of-frame mark reports `frameBits` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fieldOn | input | 1 | Synchronised field level, 1 = field on |
| bitValid | output | 1 | One-cycle strobe for a decoded bit |
| bitValue | output | 1 | Value of the decoded bit, valid with `bitValid` |
| frameEnd | output | 1 | One-cycle end-of-frame strobe |
| frameBits | output | $clog2(MAX_BITS+1) | Bit count of the finished frame, valid with `frameEnd` |
| protoErr | output | 1 | One-cycle protocol error strobe |
| rxReset | output | 1 | One-cycle strobe after a long field-off period |

## Verification
The bench builds the decoder with `CLKS_PER_UNIT` = 2 and `RESET_UNITS` = 60, and keeps the symbol windows at their defaults. Two clocks per unit means the prescaler restart at each edge is exercised, so a level one cycle short of a boundary lands in the lower unit count. The short reset threshold brings the long-off reset, together with the counter saturation that follows it, within a few hundred cycles. With it, a 59-unit gap can be compared against a 60-unit one and against an off period of 120 units.

// File: rtl/pldec_pkg.sv
package pldec_pkg;

  // Observations the datapath hands to the control each cycle
  typedef struct packed {
    logic rise;      // field turned on this cycle
    logic fall;      // field turned off this cycle
    logic level;     // level of the run being measured
    logic inZero;    // finished run length lies in the zero window
    logic inOne;     // finished run length lies in the one window
    logic gapOk;     // finished run length lies in the gap window
    logic hitEof;    // on-run just reached the end-of-frame length
    logic hitReset;  // off-run just reached the reset length
  } dpObs_t;

  // Strobes the control sends to the datapath
  typedef struct packed {
    logic clrBits;   // start a new frame's bit count
    logic incBits;   // one more bit decoded
    logic snapBits;  // capture the count for the frame-end strobe
  } ctlCmd_t;

  typedef enum logic [1:0] {
    ST_IDLE,   // waiting for the first falling edge of a frame
    ST_GAP,    // inside an off gap of a frame
    ST_MARK,   // inside an on interval of a frame
    ST_HOLD    // after an error, waiting for a long on interval
  } rxState_t;

endpackage

// File: rtl/pldec_datapath.sv
module pldec_datapath
  import pldec_pkg::*;
#(
  parameter int CLKS_PER_UNIT = 400,
  parameter int ZERO_MIN      = 14,
  parameter int ZERO_MAX      = 22,
  parameter int ONE_MIN       = 26,
  parameter int ONE_MAX       = 32,
  parameter int EOF_MIN       = 38,
  parameter int GAP_MIN       = 4,
  parameter int GAP_MAX       = 10,
  parameter int RESET_UNITS   = 4375,
  parameter int MAX_BITS      = 255,
  localparam int BW           = $clog2(MAX_BITS + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          fieldOn,
  input  ctlCmd_t       cmd,
  output dpObs_t        obs,
  output logic [BW-1:0] frameBits
);

  // The run counter must be able to pass the largest threshold it is compared with
  localparam int TOP_LEN = (RESET_UNITS > EOF_MIN) ? RESET_UNITS : EOF_MIN;
  localparam int CW      = $clog2(TOP_LEN + 2);
  localparam logic [CW-1:0] RUN_MAX = {CW{1'b1}};
  localparam logic [BW-1:0] BIT_MAX = BW'(MAX_BITS);

  logic          levelQ;
  logic [CW-1:0] runQ;
  logic          stepQ;
  logic [BW-1:0] bitCntQ;
  logic [BW-1:0] frameBitsQ;

  logic          edgeNow;
  logic          unitDone;
  logic [CW-1:0] baseRun;
  logic          runSat;

  assign edgeNow = fieldOn ^ levelQ;
  assign baseRun = edgeNow ? '0 : runQ;
  assign runSat  = (baseRun == RUN_MAX);

  // Unit prescaler, restarted at every field edge so each run is counted exactly
  generate
    if (CLKS_PER_UNIT == 1) begin : g_noPrescale
      assign unitDone = 1'b1;
    end else begin : g_prescale
      localparam int PW = $clog2(CLKS_PER_UNIT);
      logic [PW-1:0] preQ;
      logic [PW-1:0] basePre;
      assign basePre  = edgeNow ? '0 : preQ;
      assign unitDone = (basePre == PW'(CLKS_PER_UNIT - 1));
      always_ff @(posedge clk) begin
        if (!rstN)         preQ <= '0;
        else if (unitDone) preQ <= '0;
        else               preQ <= basePre + 1'b1;
      end
    end
  endgenerate

  // Run-length counter shared by off gaps and on intervals; saturates
  always_ff @(posedge clk) begin
    if (!rstN) begin
      levelQ <= 1'b0;
      runQ   <= '0;
      stepQ  <= 1'b0;
    end else begin
      levelQ <= fieldOn;
      stepQ  <= unitDone & ~runSat;
      if (unitDone && !runSat) runQ <= baseRun + 1'b1;
      else                     runQ <= baseRun;
    end
  end

  // Bit counter of the current frame and the captured frame length
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCntQ    <= '0;
      frameBitsQ <= '0;
    end else begin
      if (cmd.snapBits) frameBitsQ <= bitCntQ;
      if (cmd.clrBits)                             bitCntQ <= '0;
      else if (cmd.incBits && bitCntQ != BIT_MAX)  bitCntQ <= bitCntQ + 1'b1;
    end
  end

  assign frameBits = frameBitsQ;

  always_comb begin
    obs          = '0;
    obs.rise     = fieldOn & ~levelQ;
    obs.fall     = ~fieldOn & levelQ;
    obs.level    = levelQ;
    obs.inZero   = (runQ >= CW'(ZERO_MIN)) && (runQ <= CW'(ZERO_MAX));
    obs.inOne    = (runQ >= CW'(ONE_MIN))  && (runQ <= CW'(ONE_MAX));
    obs.gapOk    = (runQ >= CW'(GAP_MIN))  && (runQ <= CW'(GAP_MAX));
    obs.hitEof   = stepQ & levelQ  & (runQ == CW'(EOF_MIN));
    obs.hitReset = stepQ & ~levelQ & (runQ == CW'(RESET_UNITS));
  end

  // R8: within a run the measured length never goes down
  assert_run_monotonic_R8: assert property (@(posedge clk) disable iff (!rstN)
    !edgeNow |=> (runQ >= $past(runQ)));

  // R7: a saturated run stays saturated until the next edge (no wrap)
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rstN)
    (runQ == RUN_MAX && !edgeNow) |=> (runQ == RUN_MAX));

  // R11: a frame start leaves the bit count at zero
  assert_count_cleared_R11: assert property (@(posedge clk) disable iff (!rstN)
    cmd.clrBits |=> (bitCntQ == '0));

endmodule

// File: rtl/pldec_control.sv
module pldec_control
  import pldec_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  dpObs_t  obs,
  output ctlCmd_t cmd,
  output logic    bitValid,
  output logic    bitValue,
  output logic    frameEnd,
  output logic    protoErr,
  output logic    rxReset
);

  rxState_t stateQ, stateD;
  logic bitValidD, bitValueD, frameEndD, protoErrD, rxResetD;
  logic bitValidQ, bitValueQ, frameEndQ, protoErrQ, rxResetQ;

  always_comb begin
    stateD    = stateQ;
    cmd       = '0;
    bitValidD = 1'b0;
    bitValueD = 1'b0;
    frameEndD = 1'b0;
    protoErrD = 1'b0;
    rxResetD  = 1'b0;
    if (obs.hitReset) begin
      // A long field-off period overrides any frame in progress
      rxResetD = 1'b1;
      stateD   = ST_IDLE;
    end else begin
      unique case (stateQ)
        ST_IDLE: begin
          if (obs.fall) begin
            stateD      = ST_GAP;
            cmd.clrBits = 1'b1;
          end
        end
        ST_GAP: begin
          if (obs.rise) begin
            if (obs.gapOk) begin
              stateD = ST_MARK;
            end else begin
              protoErrD = 1'b1;
              stateD    = ST_HOLD;
            end
          end
        end
        ST_MARK: begin
          if (obs.hitEof) begin
            frameEndD    = 1'b1;
            cmd.snapBits = 1'b1;
            if (obs.fall) begin
              stateD      = ST_GAP;
              cmd.clrBits = 1'b1;
            end else begin
              stateD = ST_IDLE;
            end
          end else if (obs.fall) begin
            if (obs.inZero || obs.inOne) begin
              bitValidD   = 1'b1;
              bitValueD   = obs.inOne;
              cmd.incBits = 1'b1;
              stateD      = ST_GAP;
            end else begin
              protoErrD = 1'b1;
              stateD    = ST_HOLD;
            end
          end
        end
        ST_HOLD: begin
          if (obs.hitEof) begin
            if (obs.fall) begin
              stateD      = ST_GAP;
              cmd.clrBits = 1'b1;
            end else begin
              stateD = ST_IDLE;
            end
          end
        end
        default: stateD = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ    <= ST_IDLE;
      bitValidQ <= 1'b0;
      bitValueQ <= 1'b0;
      frameEndQ <= 1'b0;
      protoErrQ <= 1'b0;
      rxResetQ  <= 1'b0;
    end else begin
      stateQ    <= stateD;
      bitValidQ <= bitValidD;
      bitValueQ <= bitValueD;
      frameEndQ <= frameEndD;
      protoErrQ <= protoErrD;
      rxResetQ  <= rxResetD;
    end
  end

  assign bitValid = bitValidQ;
  assign bitValue = bitValueQ;
  assign frameEnd = frameEndQ;
  assign protoErr = protoErrQ;
  assign rxReset  = rxResetQ;

  // R10: at most one event strobe per cycle
  assert_strobes_exclusive_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({bitValidQ, frameEndQ, protoErrQ, rxResetQ}));

  // R7: the reset strobe lasts one cycle
  assert_reset_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    rxResetQ |=> !rxResetQ);

  // R1: a bit is only decided on a falling edge of the field
  assert_bit_on_fall_R1: assert property (@(posedge clk) disable iff (!rstN)
    bitValidQ |-> $past(obs.fall));

  // R3: end of frame is decided while the field is still on
  assert_eof_while_on_R3: assert property (@(posedge clk) disable iff (!rstN)
    frameEndQ |-> $past(obs.level));

  // R6: nothing is decoded while waiting after an error
  assert_hold_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_HOLD) |=> (!bitValidQ && !frameEndQ));

endmodule

// File: rtl/pulse_len_decoder.sv
module pulse_len_decoder
  import pldec_pkg::*;
#(
  parameter int CLKS_PER_UNIT = 400,
  parameter int ZERO_MIN      = 14,
  parameter int ZERO_MAX      = 22,
  parameter int ONE_MIN       = 26,
  parameter int ONE_MAX       = 32,
  parameter int EOF_MIN       = 38,
  parameter int GAP_MIN       = 4,
  parameter int GAP_MAX       = 10,
  parameter int RESET_UNITS   = 4375,
  parameter int MAX_BITS      = 255
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          fieldOn,
  output logic                          bitValid,
  output logic                          bitValue,
  output logic                          frameEnd,
  output logic [$clog2(MAX_BITS+1)-1:0] frameBits,
  output logic                          protoErr,
  output logic                          rxReset
);

  dpObs_t  obs;
  ctlCmd_t cmd;

  pldec_datapath #(
    .CLKS_PER_UNIT(CLKS_PER_UNIT), .ZERO_MIN(ZERO_MIN), .ZERO_MAX(ZERO_MAX),
    .ONE_MIN(ONE_MIN), .ONE_MAX(ONE_MAX), .EOF_MIN(EOF_MIN),
    .GAP_MIN(GAP_MIN), .GAP_MAX(GAP_MAX), .RESET_UNITS(RESET_UNITS),
    .MAX_BITS(MAX_BITS)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .fieldOn(fieldOn),
    .cmd(cmd), .obs(obs), .frameBits(frameBits)
  );

  pldec_control i_control (
    .clk(clk), .rstN(rstN), .obs(obs), .cmd(cmd),
    .bitValid(bitValid), .bitValue(bitValue), .frameEnd(frameEnd),
    .protoErr(protoErr), .rxReset(rxReset)
  );

endmodule

// File: tb/test_pulse_len_decoder.sv
`timescale 1ns/1ps
module test_pulse_len_decoder;

  localparam int CPU   = 2;
  localparam int RSTU  = 60;
  localparam int GAPU  = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fieldOn = 1'b1;
  logic bitValid, bitValue, frameEnd, protoErr, rxReset;
  logic [7:0] frameBits;

  pulse_len_decoder #(.CLKS_PER_UNIT(CPU), .RESET_UNITS(RSTU)) i_pulse_len_decoder (
    .clk(clk), .rstN(rstN), .fieldOn(fieldOn), .bitValid(bitValid),
    .bitValue(bitValue), .frameEnd(frameEnd), .frameBits(frameBits),
    .protoErr(protoErr), .rxReset(rxReset)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // Event monitor, sampling away from the active edge
  int nBits = 0, nFrames = 0, nErr = 0, nRst = 0, multiHigh = 0, rstLong = 0;
  int lastFrameBits = -1;
  logic bitsSeen [256];
  logic prevRst = 1'b0;

  always @(negedge clk) begin
    if (rstN) begin
      if ((int'(bitValid) + int'(frameEnd) + int'(protoErr) + int'(rxReset)) > 1) multiHigh++;
      if (bitValid) begin bitsSeen[nBits % 256] = bitValue; nBits++; end
      if (frameEnd) begin nFrames++; lastFrameBits = int'(frameBits); end
      if (protoErr) nErr++;
      if (rxReset) nRst++;
      if (rxReset && prevRst) rstLong++;
      prevRst = rxReset;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Drive a level for a number of whole units / clocks, starting at a negedge
  task automatic holdU(input logic lvl, input int units);
    fieldOn = lvl;
    repeat (units * CPU) @(negedge clk);
  endtask

  task automatic holdC(input logic lvl, input int clocks);
    fieldOn = lvl;
    repeat (clocks) @(negedge clk);
  endtask

  task automatic sym(input int onUnits);
    holdU(1'b0, GAPU);
    holdU(1'b1, onUnits);
  endtask

  task automatic idleOn();
    holdU(1'b1, 50);
  endtask

  task automatic t_reset_state();
    chk("R9 bitValid at reset", int'(bitValid), 0);
    chk("R9 frameEnd at reset", int'(frameEnd), 0);
    chk("R9 protoErr at reset", int'(protoErr), 0);
    chk("R9 rxReset at reset", int'(rxReset), 0);
  endtask

  task automatic t_basic_frame();
    int b0, f0, e0;
    int pat [8] = '{1, 0, 1, 1, 0, 0, 1, 0};
    b0 = nBits; f0 = nFrames; e0 = nErr;
    idleOn();
    foreach (pat[i]) sym(pat[i] ? 29 : 18);
    sym(45);
    chk("R1 R2 bit count", nBits - b0, 8);
    foreach (pat[i]) chk("R1 R2 bit value", int'(bitsSeen[(b0 + i) % 256]), pat[i]);
    chk("R3 frame strobe", nFrames - f0, 1);
    chk("R3 frameBits", lastFrameBits, 8);
    chk("R4 no error on good frame", nErr - e0, 0);
  endtask

  task automatic t_window_edges();
    int b0;
    b0 = nBits;
    idleOn();
    sym(14); sym(22); sym(26); sym(32);
    sym(45);
    chk("R1 R2 edge bit count", nBits - b0, 4);
    chk("R1 zero at 14", int'(bitsSeen[b0 % 256]), 0);
    chk("R1 zero at 22", int'(bitsSeen[(b0 + 1) % 256]), 0);
    chk("R2 one at 26", int'(bitsSeen[(b0 + 2) % 256]), 1);
    chk("R2 one at 32", int'(bitsSeen[(b0 + 3) % 256]), 1);
    chk("R11 frameBits edge frame", lastFrameBits, 4);
  endtask

  task automatic t_eof_early();
    int f0;
    f0 = nFrames;
    idleOn();
    sym(29);
    holdU(1'b0, GAPU);
    holdU(1'b1, 37);
    chk("R3 no frame end at 37 units", nFrames - f0, 0);
    holdU(1'b1, 3);
    chk("R3 frame end while field on", nFrames - f0, 1);
    chk("R3 frameBits one bit", lastFrameBits, 1);
    holdU(1'b1, 10);
  endtask

  task automatic t_bad_windows();
    int lens [5] = '{13, 23, 25, 33, 37};
    foreach (lens[i]) begin
      int b0, f0, e0;
      b0 = nBits; f0 = nFrames; e0 = nErr;
      idleOn();
      sym(lens[i]);
      sym(45);
      chk($sformatf("R4 error for on=%0d", lens[i]), nErr - e0, 1);
      chk($sformatf("R4 no bit for on=%0d", lens[i]), nBits - b0, 0);
      chk($sformatf("R4 no frame for on=%0d", lens[i]), nFrames - f0, 0);
    end
  endtask

  task automatic t_sub_unit();
    int b0, e0;
    b0 = nBits; e0 = nErr;
    idleOn();
    holdU(1'b0, GAPU);
    holdC(1'b1, 14 * CPU - 1);
    holdU(1'b0, GAPU);
    holdU(1'b1, 45);
    chk("R8 one clock short of 14 is an error", nErr - e0, 1);
    chk("R8 no bit when short", nBits - b0, 0);
  endtask

  task automatic t_gaps();
    int b0, f0, e0;
    b0 = nBits; f0 = nFrames; e0 = nErr;
    idleOn();
    holdU(1'b0, 4);  holdU(1'b1, 18);
    holdU(1'b0, 10); holdU(1'b1, 29);
    sym(45);
    chk("R5 gaps 4 and 10 accepted", nBits - b0, 2);
    chk("R5 gap frame ends", nFrames - f0, 1);
    chk("R5 no error for edge gaps", nErr - e0, 0);
    e0 = nErr; b0 = nBits;
    idleOn();
    holdU(1'b0, 3); holdU(1'b1, 18);
    sym(45);
    chk("R5 gap 3 rejected", nErr - e0, 1);
    idleOn();
    holdU(1'b0, 11); holdU(1'b1, 18);
    sym(45);
    chk("R5 gap 11 rejected", nErr - e0, 2);
    chk("R5 no bits after bad gaps", nBits - b0, 0);
  endtask

  task automatic t_hold();
    int b0, f0, e0;
    b0 = nBits; f0 = nFrames; e0 = nErr;
    idleOn();
    sym(18);
    sym(24);
    sym(18); sym(29);
    chk("R6 bits before error only", nBits - b0, 1);
    sym(45);
    chk("R6 no frame end while re-arming", nFrames - f0, 0);
    sym(29); sym(18);
    sym(45);
    chk("R6 error counted once", nErr - e0, 1);
    chk("R6 frame after re-arm", nFrames - f0, 1);
    chk("R6 frameBits after re-arm", lastFrameBits, 2);
  endtask

  task automatic t_long_off();
    int e0, r0;
    e0 = nErr; r0 = nRst;
    idleOn();
    sym(18);
    holdU(1'b0, RSTU - 1);
    holdU(1'b1, 45);
    chk("R7 no reset at threshold-1", nRst - r0, 0);
    chk("R5 over-long gap is error", nErr - e0, 1);
    e0 = nErr;
    sym(29);
    holdU(1'b0, 2 * RSTU);
    chk("R7 one reset pulse", nRst - r0, 1);
    chk("R7 reset pulse single cycle", rstLong, 0);
    chk("R7 reset is no error", nErr - e0, 0);
    idleOn();
    sym(18); sym(29); sym(18);
    sym(45);
    chk("R11 count restarts after reset", lastFrameBits, 3);
  endtask

  task automatic t_empty();
    int f0;
    f0 = nFrames;
    idleOn();
    sym(45);
    chk("R11 empty frame strobe", nFrames - f0, 1);
    chk("R11 empty frameBits", lastFrameBits, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset_state();
    rstN = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_basic_frame();
    t_window_edges();
    t_eof_early();
    t_bad_windows();
    t_sub_unit();
    t_gaps();
    t_hold();
    t_long_off();
    t_empty();
    chk("R10 strobes never overlap", multiHigh, 0);
    finishRun();
  end

endmodule